// File: doc/BRIEF.md
# PWM Generator Pair With Dead-Time Insertion

This block is a single pulse-width generator built around one 16-bit up counter. A free-running 8-bit prescaler feeds a power-of-two divider, and every divided tick advances the counter from zero up to a programmed period value. Two duty comparators set the output levels. The outputs can run as two independent PWM channels. They can also run as one complementary pair, where the second output is the inverse of the first and a programmable dead time keeps both outputs low around every switch.

Period and duty values are shadowed and take effect only when a period ends, so a change in mid-period never cuts a pulse short. A one-cycle interrupt pulse marks the end of every period. The same counter also serves as a capture timer. An external input passes through a two-flop synchronizer, and on an enabled rising or falling edge the block latches the counter value and raises a capture pulse.

Top module: `pwm_dz_pair`

## Requirements
- R1: While `rst_n` is low with `comp_en` low, `pwm_a`, `pwm_b`, `period_irq` and `cap_irq` are 0 and `cap_val` is 0.
- R2: A counter tick occurs every (`prescale`+1) × 2^k clocks. `div_sel` values 0 to 4 give k = 0 to 4, and the values 5 to 7 also give k = 4.
- R3: The counter runs from 0 to the loaded period value P, so a period lasts P+1 ticks. `period_irq` is a single-cycle pulse that recurs once per period, and the counter never exceeds P.
- R4: With `comp_en` low, `pwm_a` is high for min(`duty_a`, P+1) ticks of each period and `pwm_b` is high for min(`duty_b`, P+1) ticks. A duty of 0 keeps the output low.
- R5: `period`, `duty_a` and `duty_b` are copied into the working registers only at the end of a period. A change made in mid-period leaves the current period unchanged.
- R6: With `comp_en` high, `pwm_b` is driven from the inverse of the `pwm_a` compare result and `duty_b` has no effect. With a dead time of 0, the two outputs are exact complements.
- R7: With `comp_en` high, every change of the compare result holds both outputs low for `dead_time` prescaler ticks, and the two outputs are never high together.
- R8: `cap_in` passes through two flip-flops before edge detection. If the input changes while the counter holds value m and the counter advances every clock, `cap_val` becomes m+2 and `cap_irq` pulses for one cycle. `cap_val` changes only together with `cap_irq`.
- R9: An edge whose enable (`cap_rise_en` for rising, `cap_fall_en` for falling) is low produces no `cap_irq` and leaves `cap_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period | input | 16 | Period value P (period lasts P+1 ticks), shadowed |
| duty_a | input | 16 | Compare value for output A, shadowed |
| duty_b | input | 16 | Compare value for output B in independent mode, shadowed |
| prescale | input | 8 | Prescaler reload; divides the clock by prescale+1 |
| div_sel | input | 3 | Divider after the prescaler: 0..4 select 1,2,4,8,16; 5..7 select 16 |
| dead_time | input | 8 | Dead time in prescaler ticks |
| comp_en | input | 1 | 1 selects the complementary pair with dead time |
| cap_rise_en | input | 1 | Capture on rising edges of cap_in |
| cap_fall_en | input | 1 | Capture on falling edges of cap_in |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B (independent or complement of A) |
| period_irq | output | 1 | One-cycle pulse at the end of each period |
| cap_irq | output | 1 | One-cycle pulse when a capture occurs |
| cap_val | output | 16 | Last captured counter value |

## Verification
`period_irq` rises one clock after the edge on which the counter wraps. The outputs follow the counter with one register of delay. A capture holds the counter value of two edges after the input change, and it appears together with `cap_irq` on the third edge. The bench does not guess the phase of the counter. It measures the spacing between period pulses and sums output highs over windows exactly one period long. Counts taken this way do not depend on the offset between the window and the counter. Captures are timed from a period pulse, when the counter is known to be 0. Each expected value waits in a queue until the monitor sees `cap_irq` or `period_irq`.

// File: rtl/pwm_dz_pair.sv
module pwm_dz_pair #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty_a,
  input  logic [CW-1:0] duty_b,
  input  logic [PW-1:0] prescale,
  input  logic [2:0]    div_sel,
  input  logic [DW-1:0] dead_time,
  input  logic          comp_en,
  input  logic          cap_rise_en,
  input  logic          cap_fall_en,
  input  logic          cap_in,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          period_irq,
  output logic          cap_irq,
  output logic [CW-1:0] cap_val
);
  localparam int DIVW = 4;

  logic [PW-1:0]   pre_cnt;
  logic [DIVW-1:0] div_cnt;
  logic [DIVW-1:0] div_mask;
  logic            pre_tick, tick, wrap;
  logic [CW-1:0]   cnt, per_q, da_q, db_q;
  logic            ra_q, rb_q;
  logic [DW-1:0]   dz;
  logic [2:0]      cap_sync;
  logic            cap_rise, cap_fall, cap_ev;

  always_comb begin
    case (div_sel)
      3'd0:    div_mask = 4'b0000;
      3'd1:    div_mask = 4'b0001;
      3'd2:    div_mask = 4'b0011;
      3'd3:    div_mask = 4'b0111;
      default: div_mask = 4'b1111;
    endcase
  end

  assign pre_tick = pre_cnt >= prescale;
  assign tick     = pre_tick && ((div_cnt & div_mask) == div_mask);
  assign wrap     = tick && (cnt == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt    <= '0;
      div_cnt    <= '0;
      cnt        <= '0;
      per_q      <= '0;
      da_q       <= '0;
      db_q       <= '0;
      period_irq <= 1'b0;
    end else begin
      pre_cnt    <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= div_cnt + 1'b1;
      period_irq <= wrap;
      if (wrap) begin
        cnt   <= '0;
        per_q <= period;
        da_q  <= duty_a;
        db_q  <= duty_b;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= 1'b0;
      rb_q <= 1'b0;
      dz   <= '0;
    end else begin
      ra_q <= cnt < da_q;
      rb_q <= cnt < db_q;
      if (comp_en && ((cnt < da_q) != ra_q)) dz <= dead_time;
      else if (pre_tick && dz != '0)         dz <= dz - 1'b1;
    end
  end

  assign pwm_a = comp_en ? (ra_q && dz == '0)  : ra_q;
  assign pwm_b = comp_en ? (!ra_q && dz == '0) : rb_q;

  assign cap_rise = cap_sync[1] && !cap_sync[2];
  assign cap_fall = !cap_sync[1] && cap_sync[2];
  assign cap_ev   = (cap_rise && cap_rise_en) || (cap_fall && cap_fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sync <= '0;
      cap_irq  <= 1'b0;
      cap_val  <= '0;
    end else begin
      cap_sync <= {cap_sync[1:0], cap_in};
      cap_irq  <= cap_ev;
      if (cap_ev) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/pwm_dz_pair_sva.sv
module pwm_dz_pair_sva #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          comp_en,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic          period_irq,
  input logic          cap_irq,
  input logic          cap_rise_en,
  input logic          cap_fall_en,
  input logic [CW-1:0] cap_val,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_q
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> !(pwm_a && pwm_b)); // R7
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_q); // R3
  AST_SHADOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> period_irq); // R5
  AST_CAP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_val) |-> cap_irq); // R8
  AST_CAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> $past(cap_rise_en || cap_fall_en)); // R9
endmodule

bind pwm_dz_pair pwm_dz_pair_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .comp_en(comp_en), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .period_irq(period_irq), .cap_irq(cap_irq), .cap_rise_en(cap_rise_en),
  .cap_fall_en(cap_fall_en), .cap_val(cap_val), .cnt(cnt), .per_q(per_q)
);

// File: tb/pwm_dz_pair_test.sv
`timescale 1ns/1ps
module pwm_dz_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = '0, duty_a = '0, duty_b = '0;
  logic [7:0]  prescale = '0, dead_time = '0;
  logic [2:0]  div_sel = '0;
  logic        comp_en = 1'b0, cap_rise_en = 1'b0, cap_fall_en = 1'b0, cap_in = 1'b0;
  logic        pwm_a, pwm_b, period_irq, cap_irq;
  logic [15:0] cap_val;

  int     n_chk = 0, n_bad = 0;
  longint cyc = 0;
  int     iv_q[$];
  int     cap_q[$];

  pwm_dz_pair uut (
    .clk(clk), .rst_n(rst_n), .period(period), .duty_a(duty_a), .duty_b(duty_b),
    .prescale(prescale), .div_sel(div_sel), .dead_time(dead_time), .comp_en(comp_en),
    .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en), .cap_in(cap_in),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .period_irq(period_irq), .cap_irq(cap_irq),
    .cap_val(cap_val)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    longint last;
    int e;
    last = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (period_irq) begin
          if (iv_q.size() > 0) begin
            e = iv_q.pop_front();
            check("R3", "period pulse spacing", cyc - last, e);
          end
          last = cyc;
        end
        if (cap_irq) begin
          if (cap_q.size() > 0) begin
            e = cap_q.pop_front();
            check("R8", "captured value", cap_val, e);
          end else begin
            check("R9", "capture on disabled edge", 1, 0);
          end
        end
      end
    end
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic wait_irq();
    do @(negedge clk); while (!period_irq);
  endtask

  task automatic irq_spacing(string req, int per, int ps, int ds, int exp, int n);
    period = per[15:0]; prescale = ps[7:0]; div_sel = ds[2:0];
    wait_irq();
    wait_irq();
    @(posedge clk);
    for (int i = 0; i < n; i++) iv_q.push_back(exp);
    while (iv_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(req, "period pulse lasts one cycle", period_irq, 0);
  endtask

  task automatic count_win(int len, int chg_at, int new_duty,
                           output int ca, output int cb, output int both);
    ca = 0; cb = 0; both = 0;
    wait_irq();
    for (int i = 0; i < len; i++) begin
      if (i == chg_at) duty_a = new_duty[15:0];
      ca += pwm_a;
      cb += pwm_b;
      both += (pwm_a && pwm_b) ? 1 : 0;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    wait_irq();
    wait_irq();
  endtask

  initial begin
    int ca, cb, both;
    repeat (5) @(negedge clk);
    check("R1", "pwm_a in reset", pwm_a, 0);
    check("R1", "pwm_b in reset", pwm_b, 0);
    check("R1", "period_irq in reset", period_irq, 0);
    check("R1", "cap_irq in reset", cap_irq, 0);
    check("R1", "cap_val in reset", cap_val, 0);
    rst_n = 1'b1;

    irq_spacing("R3", 9, 0, 0, 10, 3);
    irq_spacing("R2", 4, 2, 1, 30, 2);
    irq_spacing("R2", 2, 0, 4, 48, 1);
    irq_spacing("R2", 1, 0, 7, 32, 1);
    irq_spacing("R3", 0, 2, 0, 3, 3);

    period = 16'd9; prescale = 8'd0; div_sel = 3'd0;
    duty_a = 16'd3; duty_b = 16'd7;
    settle();
    count_win(10, -1, 0, ca, cb, both);
    check("R4", "pwm_a highs duty 3", ca, 3);
    check("R4", "pwm_b highs duty 7", cb, 7);
    duty_a = 16'd0; duty_b = 16'd12;
    settle();
    count_win(10, -1, 0, ca, cb, both);
    check("R4", "pwm_a highs duty 0", ca, 0);
    check("R4", "pwm_b highs duty above period", cb, 10);

    duty_a = 16'd3;
    settle();
    count_win(10, 2, 6, ca, cb, both);
    check("R5", "mid-period duty change ignored", ca, 3);
    count_win(10, -1, 0, ca, cb, both);
    check("R5", "new duty in next period", ca, 6);

    period = 16'd19; duty_a = 16'd8; duty_b = 16'd2;
    dead_time = 8'd3; comp_en = 1'b1;
    settle();
    count_win(20, -1, 0, ca, cb, both);
    check("R7", "pwm_a highs with dead time 3", ca, 5);
    check("R7", "pwm_b highs with dead time 3", cb, 9);
    check("R7", "cycles with both high", both, 0);
    dead_time = 8'd0;
    settle();
    count_win(20, -1, 0, ca, cb, both);
    check("R6", "pwm_a highs no dead time", ca, 8);
    check("R6", "pwm_b is complement, duty_b ignored", cb, 12);
    dead_time = 8'd10;
    settle();
    count_win(20, -1, 0, ca, cb, both);
    check("R7", "pwm_a swallowed by long dead time", ca, 0);
    check("R7", "pwm_b highs with dead time 10", cb, 2);

    comp_en = 1'b0; dead_time = 8'd0; period = 16'd999;
    cap_rise_en = 1'b1; cap_fall_en = 1'b0;
    settle();
    wait_irq();
    repeat (20) @(negedge clk);
    cap_in = 1'b1; cap_q.push_back(22);
    while (cap_q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    cap_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R9", "cap_val after disabled falling edge", cap_val, 22);

    cap_rise_en = 1'b0; cap_fall_en = 1'b1;
    wait_irq();
    repeat (30) @(negedge clk);
    cap_in = 1'b1;
    repeat (30) @(negedge clk);
    check("R9", "cap_val after disabled rising edge", cap_val, 22);
    cap_in = 1'b0; cap_q.push_back(62);
    while (cap_q.size() > 0) @(negedge clk);

    cap_rise_en = 1'b1; cap_fall_en = 1'b1;
    wait_irq();
    repeat (10) @(negedge clk);
    cap_in = 1'b1; cap_q.push_back(12);
    repeat (30) @(negedge clk);
    cap_in = 1'b0; cap_q.push_back(42);
    while (cap_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8", "capture flag cleared after pulse", cap_irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule